// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a configurable number of level-sensitive interrupt lines (a multiple of 32, at most 512) into a few output interrupt lines. Each output serves one group of 64 inputs, and the output count is rounded up. Software programs the block through a synchronous word-addressed register port. It holds 32-bit words of per-input enable bits and of software force bits. It returns masked pending status and a per-group summary. A global steering enable and a per-output disable sit in front of the registered outputs.

Register words are stored in reverse order: input n lives in word R-1-floor(n/32), where R = NUM_IN/32. The lowest-numbered inputs therefore sit in the highest-addressed word of each bank. The enable, force and status banks are each R words long and placed back to back. The disable and summary registers follow them.

Top module: `irq_steer_agg`

## Requirements
- R1: While reset is high and in the cycle after it, every output is low, and the control, enable, force and disable registers all read zero.
- R2: Word address 0 is steering control. Enable word i is at 1+i and force word i at R+1+i. Status word i is at 2R+1+i, the disable register at 3R+1 and the group summary at 3R+2. Any other address reads zero.
- R3: Input n maps to word index R-1-floor(n/32), at bit n mod 32.
- R4: Enable words, force words, steering control and the disable register read back the value last written. The disable register keeps only its low NUM_OUT bits.
- R5: Status word i reads (input level OR force word i) AND enable word i. A write to a status address changes no register.
- R6: Output k goes high one cycle after any enabled, pending input in 64k..64k+63. It stays high while that input stays high and falls one cycle after the input drops.
- R7: While steering control is zero, every output is low.
- R8: While disable bit k is set, output k is low.
- R9: Summary bit k is the OR of group k's masked pending bits. Neither the disable register nor steering control affects it.
- R10: Read data is registered and appears in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Level interrupt inputs |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| irq_out | output | NUM_OUT | Aggregated interrupt outputs, one per 64 inputs |

## Verification
Several properties are checked on every cycle:
- Outputs stay low while steering control is zero or the matching disable bit is set.
- No output rises without pending work in its group one cycle earlier.
- Status never shows a disabled input.
- A status write leaves all state untouched.

Only the bench's scenarios can show the reversed word mapping and the exact address decode. The same holds for read-back values, level-following output behaviour and the independence of the summary register from the gates. To cover these, the bench sweeps every input of a 96-input configuration, which includes a half-filled last group.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int WORD_W     = 32;
    localparam int GROUP_IN   = 64;
    localparam int MAX_OUT    = 8;
    localparam int REG_ADDR_W = 8;

    typedef enum logic [2:0] {
        RK_CHAN,
        RK_MASK,
        RK_SET,
        RK_STAT,
        RK_MDIS,
        RK_MSTAT,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        logic [7:0] idx;
    } reg_sel_t;

    // Decode a word address into register kind and bank word index.
    function automatic reg_sel_t decode_addr(input logic [REG_ADDR_W-1:0] addr, input int nw);
        reg_sel_t s;
        int a;
        a = int'(addr);
        s.kind = RK_NONE;
        s.idx  = '0;
        if (a == 0) begin
            s.kind = RK_CHAN;
        end else if (a <= nw) begin
            s.kind = RK_MASK;
            s.idx  = 8'(a - 1);
        end else if (a <= 2 * nw) begin
            s.kind = RK_SET;
            s.idx  = 8'(a - 1 - nw);
        end else if (a <= 3 * nw) begin
            s.kind = RK_STAT;
            s.idx  = 8'(a - 1 - 2 * nw);
        end else if (a == 3 * nw + 1) begin
            s.kind = RK_MDIS;
        end else if (a == 3 * nw + 2) begin
            s.kind = RK_MSTAT;
        end
        return s;
    endfunction

    // Bank word that holds a given input number.
    function automatic int word_of_input(input int n, input int nw);
        return nw - 1 - n / WORD_W;
    endfunction

endpackage

// File: rtl/steer_regs.sv
module steer_regs
    import steer_pkg::*;
#(
    parameter int NW   = 3,
    parameter int NOUT = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  reg_sel_t                   sel,
    input  logic [WORD_W-1:0]          wdata,
    output logic [WORD_W-1:0]          chan_q,
    output logic [NW-1:0][WORD_W-1:0]  mask_q,
    output logic [NW-1:0][WORD_W-1:0]  set_q,
    output logic [NOUT-1:0]            mdis_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            mdis_q <= '0;
        end else if (wr_en) begin
            if (sel.kind == RK_CHAN) chan_q <= wdata;
            if (sel.kind == RK_MDIS) mdis_q <= wdata[NOUT-1:0];
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[w] <= '0;
                set_q[w]  <= '0;
            end else if (wr_en && sel.idx == 8'(w)) begin
                if (sel.kind == RK_MASK) mask_q[w] <= wdata;
                if (sel.kind == RK_SET)  set_q[w]  <= wdata;
            end
        end
    end

endmodule

// File: rtl/steer_pend.sv
module steer_pend
    import steer_pkg::*;
#(
    parameter int NIN  = 96,
    parameter int NW   = 3,
    parameter int NOUT = 2
) (
    input  logic [NIN-1:0]             irq_in,
    input  logic [NW-1:0][WORD_W-1:0]  mask_q,
    input  logic [NW-1:0][WORD_W-1:0]  set_q,
    output logic [NW-1:0][WORD_W-1:0]  stat_w,
    output logic [NOUT-1:0]            grp_any
);

    // Word w holds inputs 32*(NW-1-w) .. 32*(NW-1-w)+31.
    for (genvar w = 0; w < NW; w++) begin : g_stat
        assign stat_w[w] = (irq_in[WORD_W*(NW-1-w) +: WORD_W] | set_q[w]) & mask_q[w];
    end

    // Group k covers the words holding inputs 64k..64k+63.
    for (genvar k = 0; k < NOUT; k++) begin : g_grp
        localparam int WLO = NW - 1 - 2 * k;
        if (2 * k + 1 < NW) begin : g_full
            assign grp_any[k] = (|stat_w[WLO]) | (|stat_w[WLO-1]);
        end else begin : g_half
            assign grp_any[k] = |stat_w[WLO];
        end
    end

endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg
    import steer_pkg::*;
#(
    parameter int NUM_IN = 96
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_IN-1:0]                   irq_in,
    input  logic                                reg_en,
    input  logic                                reg_we,
    input  logic [REG_ADDR_W-1:0]               reg_addr,
    input  logic [WORD_W-1:0]                   reg_wdata,
    output logic [WORD_W-1:0]                   reg_rdata,
    output logic [(NUM_IN+GROUP_IN-1)/GROUP_IN-1:0] irq_out
);

    localparam int NW   = NUM_IN / WORD_W;
    localparam int NOUT = (NUM_IN + GROUP_IN - 1) / GROUP_IN;

    reg_sel_t                  sel;
    logic                      wr_en;
    logic [WORD_W-1:0]         chan_q;
    logic [NW-1:0][WORD_W-1:0] mask_q;
    logic [NW-1:0][WORD_W-1:0] set_q;
    logic [NOUT-1:0]           mdis_q;
    logic [NW-1:0][WORD_W-1:0] stat_w;
    logic [NOUT-1:0]           grp_any;
    logic [WORD_W-1:0]         rd_mux;

    assign sel   = decode_addr(reg_addr, NW);
    assign wr_en = reg_en & reg_we;

    steer_regs #(.NW(NW), .NOUT(NOUT)) regs_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (reg_wdata),
        .chan_q (chan_q),
        .mask_q (mask_q),
        .set_q  (set_q),
        .mdis_q (mdis_q)
    );

    steer_pend #(.NIN(NUM_IN), .NW(NW), .NOUT(NOUT)) pend_i (
        .irq_in  (irq_in),
        .mask_q  (mask_q),
        .set_q   (set_q),
        .stat_w  (stat_w),
        .grp_any (grp_any)
    );

    always_comb begin
        rd_mux = '0;
        case (sel.kind)
            RK_CHAN:  rd_mux = chan_q;
            RK_MDIS:  rd_mux = WORD_W'(mdis_q);
            RK_MSTAT: rd_mux = WORD_W'(grp_any);
            RK_MASK, RK_SET, RK_STAT: begin
                for (int w = 0; w < NW; w++) begin
                    if (sel.idx == 8'(w)) begin
                        if (sel.kind == RK_MASK)     rd_mux = mask_q[w];
                        else if (sel.kind == RK_SET) rd_mux = set_q[w];
                        else                         rd_mux = stat_w[w];
                    end
                end
            end
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            irq_out   <= '0;
        end else begin
            if (reg_en && !reg_we) reg_rdata <= rd_mux;
            irq_out <= (chan_q != '0) ? (grp_any & ~mdis_q) : '0;
        end
    end

endmodule

// File: rtl/irq_steer_agg_chk.sv
module irq_steer_agg_chk
    import steer_pkg::*;
#(
    parameter int NW   = 3,
    parameter int NOUT = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NOUT-1:0]           irq_out,
    input logic [WORD_W-1:0]         chan_q,
    input logic [NOUT-1:0]           mdis_q,
    input logic [NOUT-1:0]           grp_any,
    input logic [NW-1:0][WORD_W-1:0] mask_q,
    input logic [NW-1:0][WORD_W-1:0] set_q,
    input logic [NW-1:0][WORD_W-1:0] stat_w,
    input reg_sel_t                  sel,
    input logic                      wr_en
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (irq_out == '0 && chan_q == '0 && mdis_q == '0 && mask_q == '0 && set_q == '0));

    a_r7_chan_gate: assert property (@(posedge clk) disable iff (rst)
        (chan_q == '0) |=> (irq_out == '0));

    a_r8_mdis_gate: assert property (@(posedge clk) disable iff (rst)
        (mdis_q != '0) |=> ((irq_out & $past(mdis_q)) == '0));

    a_r6_out_has_source: assert property (@(posedge clk) disable iff (rst)
        (irq_out != '0) |-> ((irq_out & ~$past(grp_any)) == '0));

    a_r5_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        ((stat_w & ~mask_q) == '0));

    a_r5_stat_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel.kind == RK_STAT) |=>
            ($stable(mask_q) && $stable(set_q) && $stable(chan_q) && $stable(mdis_q)));

endmodule

bind irq_steer_agg irq_steer_agg_chk #(.NW(NW), .NOUT(NOUT)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .irq_out (irq_out),
    .chan_q  (chan_q),
    .mdis_q  (mdis_q),
    .grp_any (grp_any),
    .mask_q  (mask_q),
    .set_q   (set_q),
    .stat_w  (stat_w),
    .sel     (sel),
    .wr_en   (wr_en)
);

// File: tb/irq_steer_agg_tb_top.sv
module irq_steer_agg_tb_top;

    localparam int NIN  = 96;
    localparam int NW   = NIN / 32;
    localparam int NOUT = (NIN + 63) / 64;
    localparam int A_MDIS  = 3 * NW + 1;
    localparam int A_MSTAT = 3 * NW + 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NIN-1:0]  irq_in = '0;
    logic            reg_en = 1'b0;
    logic            reg_we = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NOUT-1:0] irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    irq_steer_agg #(.NUM_IN(NIN)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 8'(addr); reg_wdata = data;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = 8'(addr);
        @(negedge clk);
        reg_en = 1'b0;
        data = reg_rdata;
    endtask

    function automatic logic [31:0] out_bit(input int n);
        return 32'(1) << (n / 64);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out in reset", 32'(irq_out), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out after reset", 32'(irq_out), 32'h0);
        rd(0, d);      check("R1 chan", d, 32'h0);
        rd(1, d);      check("R1 mask0", d, 32'h0);
        rd(NW + 1, d); check("R1 set0", d, 32'h0);
        rd(A_MDIS, d); check("R1 mdis", d, 32'h0);

        // R4 / R10: read-back of enable words
        wr(0, 32'h1);
        rd(0, d); check("R4 chan readback", d, 32'h1);
        for (int w = 0; w < NW; w++) begin
            wr(1 + w, 32'hA5A5_0000 + 32'(w));
            rd(1 + w, d); check("R10 R4 mask readback", d, 32'hA5A5_0000 + 32'(w));
        end
        for (int w = 0; w < NW; w++) wr(1 + w, 32'hFFFF_FFFF);

        // R3 R5 R6 R9: single-input sweep over all inputs
        for (int n = 0; n < NIN; n++) begin
            @(negedge clk);
            irq_in = '0;
            irq_in[n] = 1'b1;
            @(negedge clk);
            check("R6 output for input", 32'(irq_out), out_bit(n));
            rd(2 * NW + 1 + (NW - 1 - n / 32), d);
            check("R3 status bit", d, 32'(1) << (n % 32));
            rd(A_MSTAT, d);
            check("R9 summary", d, out_bit(n));
        end

        // R6: level following
        @(negedge clk); irq_in = '0; irq_in[70] = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 held high", 32'(irq_out), 32'h2);
        irq_in = '0;
        @(negedge clk);
        check("R6 falls after drop", 32'(irq_out), 32'h0);

        // R5: enable bit 0 blocks input
        wr(NW, 32'hFFFF_FFFE);
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk);
        check("R5 masked output", 32'(irq_out), 32'h0);
        rd(3 * NW, d); check("R5 masked status", d, 32'h0);
        irq_in = '0;
        wr(NW, 32'hFFFF_FFFF);

        // R5: force bit makes input 67 pending (word 0 bit 3)
        wr(NW + 1, 32'h8);
        @(negedge clk);
        check("R5 force output", 32'(irq_out), 32'h2);
        rd(NW + 1, d); check("R4 set readback", d, 32'h8);
        rd(2 * NW + 1, d); check("R5 force status", d, 32'h8);

        // R5: status write ignored
        wr(2 * NW + 1, 32'h0);
        rd(1, d);          check("R5 mask kept", d, 32'hFFFF_FFFF);
        rd(NW + 1, d);     check("R5 set kept", d, 32'h8);
        rd(2 * NW + 1, d); check("R5 status kept", d, 32'h8);

        // R8 R9: disable output 1
        wr(A_MDIS, 32'hFFFF_FFFE);
        rd(A_MDIS, d); check("R4 mdis width", d, 32'h2);
        @(negedge clk);
        check("R8 disabled", 32'(irq_out), 32'h0);
        rd(A_MSTAT, d); check("R9 summary ignores disable", d, 32'h2);
        wr(A_MDIS, 32'h1);
        @(negedge clk);
        check("R8 other output", 32'(irq_out), 32'h2);
        wr(A_MDIS, 32'h0);

        // R7: steering off
        wr(0, 32'h0);
        @(negedge clk);
        check("R7 chan zero", 32'(irq_out), 32'h0);
        rd(A_MSTAT, d); check("R9 summary ignores chan", d, 32'h2);
        wr(0, 32'h4);
        @(negedge clk);
        check("R7 chan back", 32'(irq_out), 32'h2);

        // R2: unmapped addresses
        rd(A_MSTAT + 1, d); check("R2 unmapped", d, 32'h0);
        rd(8'hFF, d);       check("R2 unmapped top", d, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule